// File: doc/BRIEF.md
# UART Host Register Interface

This block is the processor-side register model of one UART channel. A host reads and writes byte registers through a single-cycle bus: two mode registers behind a pointer, a status byte, a command byte, a data register, and an interrupt register. Writes to the data register load the outbound byte. Reads of the data register take the oldest received byte.

On the line side, bytes leave through a valid/ready output port and arrive through a valid/ready input port. A break pulse from the line logic records a break and queues a zero byte. Serial shifting, baud timing and error detection belong to the line logic and are not part of this block. One interrupt line reports the enabled interrupt sources.

Register index map on `bus_addr_i`: 0 mode, 1 status (read), 2 command (write), 3 data, 5 interrupt (a read returns the status, a write sets the mask). A read of any other index returns 0, and a write to any other index has no effect.

Top module: `uart_regs`

## Requirements
- R1: After reset, status reads 0x08, and the interrupt status, both mode registers and the mask read 0. `irq_o`, `tx_valid_o` and `rx_ready_o` are low.
- R2: The first mode write after reset, or after misc command 1, goes to mode register 1. Every later write goes to mode register 2. A read of index 0 returns the register that the pointer selects.
- R3: The command byte has three fields: bits 1:0 receiver (1 enable, 2 disable), bits 3:2 transmitter (1 enable, 2 disable), and bits 6:4 misc. The misc field acts first, so an enable in the same byte wins over a reset.
- R4: The status bits are: bit 0 receive ready (FIFO not empty), bit 1 FIFO full, bit 2 transmit ready (equal to the transmitter enable), and bit 3 transmitter empty. Bits 7:4 read 0.
- R5: A data write clears transmitter empty. While the transmitter is enabled and a byte is pending, `tx_valid_o` is high with the byte held stable. Transmitter empty returns to 1 only in the cycle after `tx_ready_i` accepts the byte.
- R6: Misc command 3 (transmitter reset) disables the transmitter, sets transmitter empty, and discards any pending byte.
- R7: The 4-entry receive FIFO takes `rx_data_i` only while the receiver is enabled and not full (`rx_ready_o`). Reads return bytes oldest first. A read clears full, and a read of an empty FIFO returns 0.
- R8: Misc command 2 (receiver reset) disables the receiver and empties the FIFO.
- R9: A `brk_i` pulse sets interrupt bit 2 and pushes 0x00, whatever the receiver enable. If the FIFO is full, the 0x00 replaces the newest entry. Misc command 5 clears bit 2.
- R10: Interrupt bit 0 follows transmit ready. Bit 1 follows FIFO full when mode register 1 bit 6 is set, and receive ready otherwise. `irq_o` is high when the interrupt status AND the mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Host access this cycle |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 3 | Register index |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current index (combinational) |
| tx_valid_o | output | 1 | Outbound byte valid |
| tx_data_o | output | 8 | Outbound byte |
| tx_ready_i | input | 1 | Line logic accepts outbound byte |
| rx_valid_i | input | 1 | Inbound byte valid |
| rx_data_i | input | 8 | Inbound byte |
| rx_ready_o | output | 1 | Block accepts inbound byte |
| brk_i | input | 1 | Break event pulse |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach is a break that arrives while the FIFO is full. At that point the input handshake is already closed, so the break is the only way a byte can still get in.

The stimulus first fills all four entries through the input port, checking that `rx_ready_o` falls. It then pulses `brk_i` and drains the FIFO, expecting the fourth byte to read back as 0x00. A second case sends a break while the receiver is disabled. A third case holds a transmit byte through a disable and a transmitter reset.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam logic [2:0] IDX_MODE = 3'd0;
  localparam logic [2:0] IDX_STAT = 3'd1;
  localparam logic [2:0] IDX_CMD  = 3'd2;
  localparam logic [2:0] IDX_DATA = 3'd3;
  localparam logic [2:0] IDX_IRQ  = 3'd5;

  localparam int unsigned MR1_RXSEL_BIT = 6;

  typedef struct packed {
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
  } cmd_t;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_regs_pkg::*;
(
  input  logic [7:0] cmd_i,
  output cmd_t       cmd_o
);
  logic [2:0] misc;
  assign misc = cmd_i[6:4];

  always_comb begin
    cmd_o         = '0;
    cmd_o.rx_on   = (cmd_i[1:0] == 2'd1);
    cmd_o.rx_off  = (cmd_i[1:0] == 2'd2);
    cmd_o.tx_on   = (cmd_i[3:2] == 2'd1);
    cmd_o.tx_off  = (cmd_i[3:2] == 2'd2);
    cmd_o.ptr_rst = (misc == 3'd1);
    cmd_o.rx_rst  = (misc == 3'd2);
    cmd_o.tx_rst  = (misc == 3'd3);
    cmd_o.brk_clr = (misc == 3'd5);
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       brk_i,
  input  logic [DW-1:0]              data_i,
  input  logic                       pop_i,
  input  logic                       flush_i,
  output logic [DW-1:0]              head_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q, wr_prev;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push, do_over;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign wr_prev = (wr_q == '0) ? LAST : wr_q - 1'b1;

  assign do_pop  = pop_i & ~empty_o;
  // a break against a full FIFO rewrites the newest slot
  assign do_over = brk_i & full_o & ~do_pop;
  assign do_push = (push_i | brk_i) & ~do_over;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_over) mem_q[wr_prev] <= data_i;
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  assert_brk_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && full_o && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          flush_i,
  output logic          empty_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i
);
  logic          empty_q;
  logic [DW-1:0] byte_q;

  assign empty_o    = empty_q;
  assign tx_valid_o = en_i & ~empty_q;
  assign tx_data_o  = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      byte_q  <= '0;
    end else if (flush_i) begin
      empty_q <= 1'b1;
    end else if (load_i) begin
      empty_q <= 1'b0;
      byte_q  <= data_i;
    end else if (tx_valid_o && tx_ready_i) begin
      empty_q <= 1'b1;
    end
  end

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !flush_i && !load_i) |=>
      (!empty_o && $stable(tx_data_o)));
  assert_sent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !load_i) |=> empty_o);
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_valid_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_ready_o,
  input  logic          brk_i,
  output logic          irq_o
);
  logic          wr, rd, cmd_vld;
  cmd_t          cmd;
  logic [DW-1:0] mr1_q, mr2_q, imr_q;
  logic          ptr_q, rx_en_q, tx_en_q, dbrk_q;
  logic          rx_en_d, tx_en_d;
  logic          fifo_full, fifo_empty, tx_empty;
  logic [DW-1:0] fifo_head, stat, isr;
  logic          rx_push, rx_pop, rx_flush, tx_load, tx_flush, rx_int;

  assign wr      = bus_valid_i & bus_we_i;
  assign rd      = bus_valid_i & ~bus_we_i;
  assign cmd_vld = wr & (bus_addr_i == AW'(IDX_CMD));

  uart_cmd_decode u_dec (.cmd_i(bus_wdata_i[7:0]), .cmd_o(cmd));

  // misc field first, then enable fields override
  always_comb begin
    rx_en_d = rx_en_q;
    tx_en_d = tx_en_q;
    if (cmd_vld) begin
      if (cmd.rx_rst) rx_en_d = 1'b0;
      if (cmd.tx_rst) tx_en_d = 1'b0;
      if (cmd.rx_on)  rx_en_d = 1'b1;
      if (cmd.rx_off) rx_en_d = 1'b0;
      if (cmd.tx_on)  tx_en_d = 1'b1;
      if (cmd.tx_off) tx_en_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mr1_q   <= '0;
      mr2_q   <= '0;
      ptr_q   <= 1'b0;
      imr_q   <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      dbrk_q  <= 1'b0;
    end else begin
      rx_en_q <= rx_en_d;
      tx_en_q <= tx_en_d;
      if (wr && bus_addr_i == AW'(IDX_MODE)) begin
        if (ptr_q) mr2_q <= bus_wdata_i;
        else       mr1_q <= bus_wdata_i;
        ptr_q <= 1'b1;
      end else if (cmd_vld && cmd.ptr_rst) begin
        ptr_q <= 1'b0;
      end
      if (wr && bus_addr_i == AW'(IDX_IRQ)) imr_q <= bus_wdata_i;
      if (brk_i)                            dbrk_q <= 1'b1;
      else if (cmd_vld && cmd.brk_clr)      dbrk_q <= 1'b0;
    end
  end

  assign rx_ready_o = rx_en_q & ~fifo_full & ~brk_i;
  assign rx_push    = rx_valid_i & rx_ready_o;
  assign rx_pop     = rd & (bus_addr_i == AW'(IDX_DATA));
  assign rx_flush   = cmd_vld & cmd.rx_rst;
  assign tx_load    = wr & (bus_addr_i == AW'(IDX_DATA));
  assign tx_flush   = cmd_vld & cmd.tx_rst;

  uart_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .brk_i   (brk_i),
    .data_i  (brk_i ? '0 : rx_data_i),
    .pop_i   (rx_pop),
    .flush_i (rx_flush),
    .head_o  (fifo_head),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  uart_tx_hold #(.DW(DW)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tx_en_q),
    .load_i     (tx_load),
    .data_i     (bus_wdata_i),
    .flush_i    (tx_flush),
    .empty_o    (tx_empty),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_i (tx_ready_i)
  );

  assign rx_int = mr1_q[MR1_RXSEL_BIT] ? fifo_full : ~fifo_empty;
  assign stat   = {{(DW-4){1'b0}}, tx_empty, tx_en_q, fifo_full, ~fifo_empty};
  assign isr    = {{(DW-3){1'b0}}, dbrk_q, rx_int, tx_en_q};
  assign irq_o  = |(isr & imr_q);

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      AW'(IDX_MODE): bus_rdata_o = ptr_q ? mr2_q : mr1_q;
      AW'(IDX_STAT): bus_rdata_o = stat;
      AW'(IDX_DATA): bus_rdata_o = fifo_empty ? '0 : fifo_head;
      AW'(IDX_IRQ):  bus_rdata_o = isr;
      default:       bus_rdata_o = '0;
    endcase
  end

  assert_ptr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == AW'(IDX_MODE)) |=> ptr_q);
  assert_dbrk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> isr[2]);
  assert_txrst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush |=> (stat[3] && !tx_valid_o));
  assert_rxrst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flush && !cmd.rx_on) |=> (!rx_ready_o && !stat[0]));
endmodule

// File: tb/uart_regs_tb.sv
module uart_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic       rx_valid = 0, rx_ready, brk = 0, irq;
  logic [7:0] rx_data = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .brk_i(brk), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  // drive at negedge, sample combinational read before the edge
  task automatic bus_op(input logic we, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] rdv);
    @(negedge clk);
    bus_valid = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1 rdv = bus_rdata;
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] unused;
    bus_op(1'b1, a, d, unused);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_op(1'b0, a, 8'h00, v);
    check(req, v, exp);
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    #1 check("R7 rx_ready", {7'd0, rx_ready}, 8'h01);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic brk_pulse();
    @(negedge clk);
    brk = 1;
    @(negedge clk);
    brk = 0;
  endtask

  // {req[3:0], chk, we, addr[2:0], wdata[7:0], exp[7:0]}
  localparam int NV = 21;
  localparam logic [24:0] TBL [NV] = '{
    {4'd4,  1'b1, 1'b0, 3'd1, 8'h00, 8'h08}, // R4 status at rest
    {4'd2,  1'b0, 1'b1, 3'd0, 8'h40, 8'h00}, // R2 MR1
    {4'd2,  1'b0, 1'b1, 3'd0, 8'h13, 8'h00}, // R2 MR2
    {4'd2,  1'b1, 1'b0, 3'd0, 8'h00, 8'h13},
    {4'd2,  1'b0, 1'b1, 3'd0, 8'h77, 8'h00}, // stays on MR2
    {4'd2,  1'b1, 1'b0, 3'd0, 8'h00, 8'h77},
    {4'd2,  1'b0, 1'b1, 3'd2, 8'h10, 8'h00}, // pointer back
    {4'd2,  1'b1, 1'b0, 3'd0, 8'h00, 8'h40},
    {4'd3,  1'b0, 1'b1, 3'd2, 8'h05, 8'h00}, // R3 rx+tx on
    {4'd3,  1'b1, 1'b0, 3'd1, 8'h00, 8'h0C},
    {4'd10, 1'b1, 1'b0, 3'd5, 8'h00, 8'h01}, // R10 tx int
    {4'd3,  1'b0, 1'b1, 3'd2, 8'h08, 8'h00}, // tx off
    {4'd3,  1'b1, 1'b0, 3'd1, 8'h00, 8'h08},
    {4'd10, 1'b1, 1'b0, 3'd5, 8'h00, 8'h00},
    {4'd3,  1'b0, 1'b1, 3'd2, 8'h06, 8'h00}, // rx off, tx on
    {4'd3,  1'b1, 1'b0, 3'd1, 8'h00, 8'h0C},
    {4'd6,  1'b0, 1'b1, 3'd2, 8'h31, 8'h00}, // R6 tx reset, rx on
    {4'd6,  1'b1, 1'b0, 3'd1, 8'h00, 8'h08},
    {4'd3,  1'b0, 1'b1, 3'd2, 8'h34, 8'h00}, // R3 reset then enable
    {4'd3,  1'b1, 1'b0, 3'd1, 8'h00, 8'h0C},
    {4'd4,  1'b1, 1'b0, 3'd2, 8'h00, 8'h00}  // R4 unused index reads 0
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    check("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
    rd_chk("R1 isr", 3'd5, 8'h00);
    rd_chk("R1 mode", 3'd0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      bus_op(TBL[i][19], TBL[i][18:16], TBL[i][15:8], v);
      if (TBL[i][20]) begin
        total++;
        if (v !== TBL[i][7:0]) begin
          bad++;
          $display("FAIL R%0d vec %0d act=%02h exp=%02h", TBL[i][24:21], i, v, TBL[i][7:0]);
        end
      end
    end

    // R5 handshake hold then accept
    wr(3'd3, 8'hA5);
    check("R5 tx_valid", {7'd0, tx_valid}, 8'h01);
    check("R5 tx_data", tx_data, 8'hA5);
    rd_chk("R5 status pending", 3'd1, 8'h04);
    repeat (3) @(negedge clk);
    check("R5 still valid", {7'd0, tx_valid}, 8'h01);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    check("R5 valid after accept", {7'd0, tx_valid}, 8'h00);
    rd_chk("R5 status sent", 3'd1, 8'h0C);

    // R6 pending byte dropped by transmitter reset
    wr(3'd2, 8'h08);
    wr(3'd3, 8'h5A);
    check("R5 disabled no valid", {7'd0, tx_valid}, 8'h00);
    rd_chk("R5 status disabled pending", 3'd1, 8'h00);
    wr(3'd2, 8'h30);
    rd_chk("R6 status", 3'd1, 8'h08);
    wr(3'd2, 8'h04);
    check("R6 dropped", {7'd0, tx_valid}, 8'h00);
    rd_chk("R6 status enabled", 3'd1, 8'h0C);

    // R10 mask
    wr(3'd5, 8'h01);
    check("R10 irq tx", {7'd0, irq}, 8'h01);
    wr(3'd5, 8'h02);
    check("R10 irq masked", {7'd0, irq}, 8'h00);

    // R7 fill FIFO (MR1 bit6 = 1: rx int on full)
    rx_push(8'h11);
    rd_chk("R7 status one", 3'd1, 8'h0D);
    rd_chk("R10 isr not full", 3'd5, 8'h01);
    rx_push(8'h22);
    rx_push(8'h33);
    rx_push(8'h44);
    rd_chk("R7 status full", 3'd1, 8'h0F);
    check("R7 rx_ready full", {7'd0, rx_ready}, 8'h00);
    check("R10 irq full", {7'd0, irq}, 8'h01);

    // R9 break against full FIFO
    brk_pulse();
    rd_chk("R9 isr brk", 3'd5, 8'h07);
    rd_chk("R7 read1", 3'd3, 8'h11);
    rd_chk("R7 status after read", 3'd1, 8'h0D);
    rd_chk("R7 read2", 3'd3, 8'h22);
    rd_chk("R7 read3", 3'd3, 8'h33);
    rd_chk("R9 newest replaced", 3'd3, 8'h00);
    rd_chk("R7 status empty", 3'd1, 8'h0C);
    rd_chk("R7 empty read", 3'd3, 8'h00);
    wr(3'd2, 8'h50);
    rd_chk("R9 brk cleared", 3'd5, 8'h01);

    // R10 receive source = ready
    wr(3'd2, 8'h10);
    wr(3'd0, 8'h00);
    rx_push(8'hAB);
    rd_chk("R10 isr ready src", 3'd5, 8'h03);
    check("R10 irq ready src", {7'd0, irq}, 8'h01);
    rd_chk("R7 readAB", 3'd3, 8'hAB);

    // R9 break with receiver disabled
    wr(3'd2, 8'h02);
    check("R3 rx off", {7'd0, rx_ready}, 8'h00);
    brk_pulse();
    rd_chk("R9 status brk byte", 3'd1, 8'h0D);
    rd_chk("R9 brk byte", 3'd3, 8'h00);
    wr(3'd2, 8'h50);

    // R8 receiver reset
    wr(3'd2, 8'h01);
    rx_push(8'h77);
    wr(3'd2, 8'h20);
    rd_chk("R8 status", 3'd1, 8'h0C);
    check("R8 rx_ready", {7'd0, rx_ready}, 8'h00);
    rd_chk("R8 empty", 3'd3, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule